// File: doc/BRIEF.md
# Masked-Write 32-Pin GPIO Bank

This block is a general-purpose I/O bank of 32 pins on a plain register bus: an address, a write strobe, 32 bits of write data and 32 bits of read data. Output levels and pin directions live in four halfword registers. The first pair holds the output levels and the second pair holds the directions. Each pair has a register for pins 0 to 15 and a register for pins 16 to 31.

Each write to one of these four registers carries its own bit mask. The upper half of the write word selects which bits of the lower half land in the register. Software can therefore set, clear or turn around any subset of pins in a single write, without reading the register first. Two read-only locations give the synchronized pin levels and a fixed version word.

The bank drives a per-pin output value and a per-pin output enable. It samples the raw pin levels through a two-stage synchronizer.

Top module: `wmask_gpio_bank`

## Requirements
- R1: On a write to a data or direction register, bit n (n in 0..15) of the register takes write bit n only when write bit 16+n is 1. Otherwise bit n keeps its previous value.
- R2: The output-level register at byte offset 0x00 holds pins 0..15 (pin n in bit n). The one at 0x04 holds pins 16..31, with pin 16+k in bit k. Output value n equals the stored level bit for pin n.
- R3: The direction register at 0x08 covers pins 0..15 and the one at 0x0C covers pins 16..31, with the same bit placement as R2. Output enable n equals the stored direction bit, where 1 means output and 0 means input.
- R4: Reading any of the four registers of R2 and R3 returns its stored bits in bits 15:0 and 0 in bits 31:16. Mask bits are not stored.
- R5: Offset 0x70 is read-only. It returns the pin levels with pin n in bit n, taken through two flip-flop stages. A level change presented before clock edge k is first visible after edge k+1.
- R6: Offset 0x78 is read-only and always returns 0x01000C2B.
- R7: Reset clears every level and direction bit, so all output enables and output values are 0.
- R8: Reads at any other offset, including unaligned ones, return 0. Writes to read-only or unmapped offsets change no register and no output.
- R9: Output values and enables are registered and change on the clock edge that takes the write. Read data is combinational from the current address and stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_data | input | PINS | Write word: mask in the upper half, bits in the lower half |
| rd_data | output | PINS | Read word for the current address |
| pin_in | input | PINS | Raw pin levels |
| pin_out | output | PINS | Per-pin output value |
| pin_oe | output | PINS | Per-pin output enable, 1 means output |

## Verification
The bench drives inputs on the falling edge. A write therefore takes effect at the next rising edge, and the bench compares pin_out, pin_oe and the register read-back at the falling edge after it. It also samples just before that edge to confirm that the outputs have not moved early. Reads are combinational, so the bench samples them shortly after it sets the address. A change on the pins is checked twice at offset 0x70: one falling edge after the change, when the old level must still show, and one edge later, when the new level is due.

// File: rtl/wmask_gpio_pkg.sv
package wmask_gpio_pkg;
    localparam int HALF_REGS = 4;
    localparam int REG_BYTES = 4;
    localparam int IDX_LVL_LO = 0;
    localparam int IDX_LVL_HI = 1;
    localparam int IDX_DIR_LO = 2;
    localparam int IDX_DIR_HI = 3;
    localparam logic [7:0]  OFF_PIN_LEVELS = 8'h70;
    localparam logic [7:0]  OFF_VERSION    = 8'h78;
    localparam logic [31:0] VERSION_WORD   = 32'h0100_0C2B;
endpackage

// File: rtl/wmask_gpio_sync.sv
module wmask_gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wmask_gpio_half.sv
module wmask_gpio_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } half_state_t;

    half_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = (st_q.bits & ~wr_mask) | (wr_bits & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bits;
endmodule

// File: rtl/wmask_gpio_bank.sv
module wmask_gpio_bank
    import wmask_gpio_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wr_data,
    output logic [PINS-1:0]   rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    localparam int HALF = PINS / 2;

    logic [HALF-1:0] half_q [HALF_REGS];
    logic [PINS-1:0] pins_sync;

    for (genvar g = 0; g < HALF_REGS; g++) begin : g_half
        logic sel;
        assign sel = wr_en && (addr == ADDR_W'(g * REG_BYTES));
        wmask_gpio_half #(.W(HALF)) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel),
            .wr_mask (wr_data[PINS-1:HALF]),
            .wr_bits (wr_data[HALF-1:0]),
            .q       (half_q[g])
        );
    end

    wmask_gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    assign pin_out = {half_q[IDX_LVL_HI], half_q[IDX_LVL_LO]};
    assign pin_oe  = {half_q[IDX_DIR_HI], half_q[IDX_DIR_LO]};

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < HALF_REGS; i++) begin
            if (addr == ADDR_W'(i * REG_BYTES)) begin
                rd_data[HALF-1:0] = half_q[i];
            end
        end
        if (addr == ADDR_W'(OFF_PIN_LEVELS)) begin
            rd_data = pins_sync;
        end
        if (addr == ADDR_W'(OFF_VERSION)) begin
            rd_data = PINS'(VERSION_WORD);
        end
    end
endmodule

// File: rtl/wmask_gpio_chk.sv
module wmask_gpio_chk
    import wmask_gpio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PINS   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [PINS-1:0]   wr_data,
    input logic [PINS-1:0]   rd_data,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    localparam int HALF = PINS / 2;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    logic in_map;
    assign in_map = (addr == ADDR_W'(0)) || (addr == ADDR_W'(4)) ||
                    (addr == ADDR_W'(8)) || (addr == ADDR_W'(12));

    // R1: masked update of the low level register
    a_r1_masked_update: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0)) |=>
        pin_out[HALF-1:0] == (($past(pin_out[HALF-1:0]) & ~$past(wr_data[PINS-1:HALF]))
                            | ($past(wr_data[HALF-1:0]) & $past(wr_data[PINS-1:HALF]))));

    // R1: an all-zero mask leaves the high direction bits alone
    a_r1_zero_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(12) && wr_data[PINS-1:HALF] == '0) |=>
        $stable(pin_oe[PINS-1:HALF]));

    // R4: upper read half is zero for the four halfword registers
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_map |-> rd_data[PINS-1:HALF] == '0);

    // R5: pin levels appear after two stages
    a_r5_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && addr == ADDR_W'(OFF_PIN_LEVELS)) |-> rd_data == $past(pin_in, 2));

    // R6: version word
    a_r6_version: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_VERSION)) |-> rd_data == PINS'(VERSION_WORD));

    // R7: outputs leave reset cleared
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (pin_out == '0 && pin_oe == '0));

    // R8: writes outside the four registers touch nothing
    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_map) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind wmask_gpio_bank wmask_gpio_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/wmask_gpio_bank_tb_top.sv
module wmask_gpio_bank_tb_top;
    localparam time CLK_PERIOD = 10;
    localparam int  ADDR_W = 8;
    localparam int  PINS = 32;
    localparam int  SEED = 1234;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [PINS-1:0]   wr_data = '0;
    logic [PINS-1:0]   rd_data;
    logic [PINS-1:0]   pin_in = '0;
    logic [PINS-1:0]   pin_out;
    logic [PINS-1:0]   pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model [4] = '{default: 16'h0};
    logic [31:0] pins_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wmask_gpio_bank #(.ADDR_W(ADDR_W), .PINS(PINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R4, R5, R6, R8: expected read word
    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h00: return {16'h0, model[0]};
            8'h04: return {16'h0, model[1]};
            8'h08: return {16'h0, model[2]};
            8'h0C: return {16'h0, model[3]};
            8'h70: return pins_exp;
            8'h78: return 32'h0100_0C2B;
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        #1;
        check("R9 level before edge", pin_out, {model[1], model[0]});
        check("R9 enable before edge", pin_oe, {model[3], model[2]});
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C) begin
            model[a[3:2]] = (model[a[3:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
        end
        #1;
        check("R1 R2 R8 pin_out after write", pin_out, {model[1], model[0]});
        check("R1 R3 R8 pin_oe after write", pin_oe, {model[3], model[2]});
    endtask

    task automatic do_read(logic [7:0] a, string req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rd_data, exp_read(a));
    endtask

    task automatic set_pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v; addr = 8'h70;
        @(negedge clk);
        #1;
        check("R5 old level after one edge", rd_data, pins_exp);
        @(negedge clk);
        pins_exp = v;
        #1;
        check("R5 new level after two edges", rd_data, pins_exp);
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(SEED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R7 pin_out reset", pin_out, 32'h0);
        check("R7 pin_oe reset", pin_oe, 32'h0);
        do_read(8'h00, "R7 level lo reset");
        do_read(8'h0C, "R7 dir hi reset");
        do_read(8'h78, "R6 version");

        // R1 directed
        do_write(8'h00, 32'h0000_FFFF);
        do_write(8'h00, 32'hFFFF_A5A5);
        do_write(8'h00, 32'h00F0_0000);
        do_read(8'h00, "R1 R4 masked readback");
        // R2 high half
        do_write(8'h04, 32'h0003_0001);
        do_read(8'h04, "R2 high level readback");
        // R3 direction
        do_write(8'h08, 32'hFFFF_00FF);
        do_write(8'h0C, 32'h8001_8000);
        do_read(8'h08, "R3 dir lo readback");
        // R8 ignored writes and unmapped reads
        do_write(8'h70, 32'hFFFF_FFFF);
        do_write(8'h78, 32'hFFFF_FFFF);
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'h02, 32'hFFFF_FFFF);
        do_read(8'h10, "R8 unmapped read");
        do_read(8'h02, "R8 unaligned read");
        do_read(8'h74, "R8 gap read");
        do_read(8'h78, "R6 version after write");
        // R5 pin sampling
        set_pins(32'hDEAD_BEEF);
        set_pins(32'h0000_0000);
        set_pins(32'hFFFF_FFFF);

        for (int i = 0; i < 300; i++) begin
            logic [7:0] a;
            r = $urandom();
            case (r[3:0])
                4'd0: a = 8'h70;
                4'd1: a = 8'h78;
                4'd2: a = 8'h20;
                default: a = {4'h0, r[5:4], 2'b00};
            endcase
            if (r[8]) do_write(a, $urandom());
            else do_read(a, "R4 R8 random read");
            if (r[12:9] == 4'd0) set_pins($urandom());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule